// File: doc/BRIEF.md
# SPI Command-Framed Register Access Slave

This block is the serial front end of a peripheral that a host controller drives over a four-wire SPI link (mode 0: clock idles low, data captured on the rising edge). Each frame opens with one command byte that holds the transfer direction, a read-mode bit and a 5-bit address. The byte or bytes that follow move data to or from the addressed location. Low addresses select single-byte control registers, which always take a fixed two-byte frame. A small window of higher addresses selects endpoint buffer ports, which accept open-ended bursts of bytes.

All serial pins are brought into the system clock domain through synchronizer chains, and SCK edges are detected there. On the core side the block issues single-cycle read and write strobes with an address and write data. It takes back read data the cycle after a read strobe and shifts it out on SDO, most significant bit first. Deasserting chip select at any point abandons the current byte, and any frame part that is not yet complete.

Top module: `spi_cmd_slave`

## Requirements
- R1: In the command byte, bit 7 gives the direction (1 = write, 0 = read) and bits 4..0 give the address. Bit 5 is ignored. Bit 6 is ignored on writes.
- R2: SDI is captured on SCK rising edges and SDO changes only after SCK falling edges. Both directions carry bytes most significant bit first.
- R3: A register write (address 00h..0Ch except 09h) produces exactly one `reg_wr_o` pulse, carrying the address and the first data byte. It happens after the 16th bit, and any further bytes in the same frame are ignored.
- R4: If chip select rises before the 16th bit of a register write, no write strobe of any kind is issued.
- R5: A register read issues one `reg_rd_o` pulse at the end of the command byte. The returned value appears as the second byte on SDO, and any later bytes in the frame read as 00h with no further strobe.
- R6: For buffer addresses 10h..15h written with bit 7 = 1, each completed data byte gives one `buf_wr_o` pulse. A trailing byte of fewer than 8 bits cut off by chip select is dropped.
- R7: A buffer read with bit 6 = 0 (continuous) issues `buf_rd_o` at the end of the command byte and again at the end of every completed data byte. SDO carries the successive values returned.
- R8: A buffer read with bit 6 = 1 (single) issues exactly one `buf_rd_o`. The frame returns that one byte, followed by 00h.
- R9: Addresses 09h, 0Dh..0Fh and 16h..1Fh produce no strobe of any kind. Reads of them return 00h.
- R10: While chip select is high, the SDO output enable is low and no strobe is issued. While chip select is low, the output enable is high.
- R11: After reset all strobes are low, the SDO output enable is low and SDO is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the SCK rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select from the host, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data in (SDI) |
| spi_miso | output | 1 | Serial data out (SDO) |
| spi_miso_oe | output | 1 | Output enable for the SDO pad driver |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_rd_o | output | 1 | One-cycle register read strobe |
| buf_wr_o | output | 1 | One-cycle buffer push strobe |
| buf_rd_o | output | 1 | One-cycle buffer pop strobe |
| addr_o | output | ADDR_W | Address of the current frame |
| wdata_o | output | DATA_W | Write data for the write strobes |
| reg_rdata_i | input | DATA_W | Register read data, sampled the cycle after `reg_rd_o` |
| buf_rdata_i | input | DATA_W | Buffer head data, sampled the cycle after `buf_rd_o` |

## Verification
The block's state is a bit counter, a frame phase and the latched command. If any of them is wrong, the strobe stream goes wrong: a missing, duplicated or misplaced pulse appears within four system clocks of the SCK rising edge that completes the affected byte. A wrong load or shift in the transmit path shows up on SDO one SCK falling edge after the read strobe, as a corrupted or bit-reversed byte. The bench drives frames with an independent behavioural model of the expected strobe sequence and the returned bytes. It covers aborts at awkward bit counts, unused addresses and both read modes, and compares every strobe as it occurs.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

   // Frame progress after chip select falls
   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_DATA = 2'd1,
      PH_DONE = 2'd2
   } phase_e;

   // Source of the next byte loaded into the transmit shifter
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_REG  = 2'd1,
      SRC_BUF  = 2'd2,
      SRC_ZERO = 2'd3
   } src_e;

   // Address class of a decoded command
   typedef enum logic [1:0] {
      REGION_NONE = 2'd0,
      REGION_GEN  = 2'd1,
      REGION_BUF  = 2'd2
   } region_e;

   function automatic region_e classify_addr(input int a, input int gen_last,
                                             input int gen_hole, input int buf_base,
                                             input int buf_count);
      if (a >= buf_base && a < buf_base + buf_count) return REGION_BUF;
      if (a <= gen_last && a != gen_hole) return REGION_GEN;
      return REGION_NONE;
   endfunction

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
   parameter int               WIDTH     = 3,
   parameter int               STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RESET_VAL;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RESET_VAL;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_cmd_frame.sv
module spi_cmd_frame
   import spi_cmd_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 5,
   parameter int GEN_LAST  = 12,
   parameter int GEN_HOLE  = 9,
   parameter int BUF_BASE  = 16,
   parameter int BUF_COUNT = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              bit_rise,
   input  logic              bit_in,
   output logic              reg_wr,
   output logic              reg_rd,
   output logic              buf_wr,
   output logic              buf_rd,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata,
   output src_e              load_src
);

   localparam int              CNT_W    = $clog2(DATA_W);
   localparam int              DIR_BIT  = DATA_W - 1;
   localparam int              MODE_BIT = DATA_W - 2;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   logic [DATA_W-2:0] rx_sr;
   logic [CNT_W-1:0]  bit_cnt;
   phase_e            phase;
   logic              is_wr;
   logic              single;
   region_e           region;

   logic [DATA_W-1:0] byte_val;
   logic [ADDR_W-1:0] cmd_addr;
   region_e           cmd_region;
   logic              byte_done;

   assign byte_val   = {rx_sr, bit_in};
   assign cmd_addr   = byte_val[ADDR_W-1:0];
   assign cmd_region = classify_addr(int'(cmd_addr), GEN_LAST, GEN_HOLE, BUF_BASE, BUF_COUNT);
   assign byte_done  = bit_rise && (bit_cnt == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sr    <= '0;
         bit_cnt  <= '0;
         phase    <= PH_CMD;
         is_wr    <= 1'b0;
         single   <= 1'b0;
         region   <= REGION_NONE;
         addr     <= '0;
         wdata    <= '0;
         reg_wr   <= 1'b0;
         reg_rd   <= 1'b0;
         buf_wr   <= 1'b0;
         buf_rd   <= 1'b0;
         load_src <= SRC_NONE;
      end else begin
         reg_wr   <= 1'b0;
         reg_rd   <= 1'b0;
         buf_wr   <= 1'b0;
         buf_rd   <= 1'b0;
         load_src <= SRC_NONE;
         if (!cs_act) begin
            bit_cnt <= '0;
            phase   <= PH_CMD;
         end else if (bit_rise) begin
            rx_sr   <= byte_val[DATA_W-2:0];
            bit_cnt <= byte_done ? '0 : bit_cnt + CNT_W'(1);
            if (byte_done) begin
               unique case (phase)
                  PH_CMD: begin
                     is_wr  <= byte_val[DIR_BIT];
                     single <= byte_val[MODE_BIT];
                     addr   <= cmd_addr;
                     region <= cmd_region;
                     phase  <= PH_DATA;
                     if (!byte_val[DIR_BIT]) begin
                        unique case (cmd_region)
                           REGION_GEN: begin
                              reg_rd   <= 1'b1;
                              load_src <= SRC_REG;
                           end
                           REGION_BUF: begin
                              buf_rd   <= 1'b1;
                              load_src <= SRC_BUF;
                           end
                           default: load_src <= SRC_ZERO;
                        endcase
                     end
                  end
                  PH_DATA: begin
                     if (is_wr) begin
                        wdata <= byte_val;
                        if (region == REGION_GEN) begin
                           reg_wr <= 1'b1;
                           phase  <= PH_DONE;
                        end else if (region == REGION_BUF) begin
                           buf_wr <= 1'b1;
                        end else begin
                           phase  <= PH_DONE;
                        end
                     end else if (region == REGION_BUF && !single) begin
                        buf_rd   <= 1'b1;
                        load_src <= SRC_BUF;
                     end else begin
                        load_src <= SRC_ZERO;
                        phase    <= PH_DONE;
                     end
                  end
                  default: begin
                     if (!is_wr) load_src <= SRC_ZERO;
                  end
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/spi_cmd_txsr.sv
module spi_cmd_txsr #(
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              shift,
   output logic              sdo
);

   logic [DATA_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr  <= '0;
         sdo <= 1'b0;
      end else if (!cs_act) begin
         sr  <= '0;
         sdo <= 1'b0;
      end else if (load) begin
         sr  <= load_val;
      end else if (shift) begin
         sdo <= sr[DATA_W-1];
         sr  <= {sr[DATA_W-2:0], 1'b0};
      end
   end

endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
   import spi_cmd_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2,
   parameter int GEN_LAST    = 12,
   parameter int GEN_HOLE    = 9,
   parameter int BUF_BASE    = 16,
   parameter int BUF_COUNT   = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sck,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   output logic              reg_wr_o,
   output logic              reg_rd_o,
   output logic              buf_wr_o,
   output logic              buf_rd_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   input  logic [DATA_W-1:0] reg_rdata_i,
   input  logic [DATA_W-1:0] buf_rdata_i
);

   localparam int ADDR_SPAN = 1 << ADDR_W;
   localparam int PIN_W     = 3;

   if ((1 << $clog2(DATA_W)) != DATA_W || DATA_W < 4) begin : g_bad_data_w
      $error("DATA_W must be a power of two and at least 4");
   end
   if (ADDR_W > DATA_W - 3) begin : g_bad_addr_w
      $error("ADDR_W leaves no room for direction and mode bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (GEN_LAST >= BUF_BASE || BUF_BASE + BUF_COUNT > ADDR_SPAN) begin : g_bad_map
      $error("register and buffer windows overlap or exceed the address space");
   end

   logic [PIN_W-1:0] pins_s;
   logic             cs_act;
   logic             sck_s;
   logic             mosi_s;
   logic             sck_d;
   logic             sck_rise;
   logic             sck_fall;

   spi_cmd_sync #(
      .WIDTH     (PIN_W),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs_n, spi_sck, spi_mosi}),
      .q     (pins_s)
   );

   assign cs_act = !pins_s[2];
   assign sck_s  = pins_s[1];
   assign mosi_s = pins_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign sck_rise = cs_act && sck_s && !sck_d;
   assign sck_fall = cs_act && !sck_s && sck_d;

   src_e              load_src;
   logic [DATA_W-1:0] load_val;

   spi_cmd_frame #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .GEN_LAST  (GEN_LAST),
      .GEN_HOLE  (GEN_HOLE),
      .BUF_BASE  (BUF_BASE),
      .BUF_COUNT (BUF_COUNT)
   ) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_act   (cs_act),
      .bit_rise (sck_rise),
      .bit_in   (mosi_s),
      .reg_wr   (reg_wr_o),
      .reg_rd   (reg_rd_o),
      .buf_wr   (buf_wr_o),
      .buf_rd   (buf_rd_o),
      .addr     (addr_o),
      .wdata    (wdata_o),
      .load_src (load_src)
   );

   always_comb begin
      unique case (load_src)
         SRC_REG: load_val = reg_rdata_i;
         SRC_BUF: load_val = buf_rdata_i;
         default: load_val = '0;
      endcase
   end

   spi_cmd_txsr #(
      .DATA_W (DATA_W)
   ) u_txsr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_act   (cs_act),
      .load     (load_src != SRC_NONE),
      .load_val (load_val),
      .shift    (sck_fall),
      .sdo      (spi_miso)
   );

   assign spi_miso_oe = cs_act;

endmodule

// File: rtl/spi_cmd_chk.sv
module spi_cmd_chk #(
   parameter int ADDR_W    = 5,
   parameter int GEN_LAST  = 12,
   parameter int GEN_HOLE  = 9,
   parameter int BUF_BASE  = 16,
   parameter int BUF_COUNT = 6
)(
   input logic              clk,
   input logic              rst_n,
   input logic              miso_oe,
   input logic              miso,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic              buf_wr,
   input logic              buf_rd,
   input logic [ADDR_W-1:0] addr,
   input logic              sck_fall
);

   logic addr_is_gen;
   logic addr_is_buf;
   logic any_strobe;

   assign addr_is_gen = (int'(addr) <= GEN_LAST) && (int'(addr) != GEN_HOLE);
   assign addr_is_buf = (int'(addr) >= BUF_BASE) && (int'(addr) < BUF_BASE + BUF_COUNT);
   assign any_strobe  = reg_wr || reg_rd || buf_wr || buf_rd;

   assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({reg_wr, reg_rd, buf_wr, buf_rd}));

   assert_gen_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr || reg_rd) |-> addr_is_gen);

   assert_buf_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_wr || buf_rd) |-> addr_is_buf);

   assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!miso_oe && !$past(miso_oe)) |-> !any_strobe);

   assert_sdo_low_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!miso_oe && !$past(miso_oe)) |-> !miso);

   assert_sdo_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (miso_oe && $past(miso_oe) && (miso != $past(miso))) |-> $past(sck_fall));

endmodule

bind spi_cmd_slave spi_cmd_chk #(
   .ADDR_W    (ADDR_W),
   .GEN_LAST  (GEN_LAST),
   .GEN_HOLE  (GEN_HOLE),
   .BUF_BASE  (BUF_BASE),
   .BUF_COUNT (BUF_COUNT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .miso_oe  (spi_miso_oe),
   .miso     (spi_miso),
   .reg_wr   (reg_wr_o),
   .reg_rd   (reg_rd_o),
   .buf_wr   (buf_wr_o),
   .buf_rd   (buf_rd_o),
   .addr     (addr_o),
   .sck_fall (sck_fall)
);

// File: tb/spi_cmd_slave_tb.sv
module spi_cmd_slave_tb;

   localparam int K_RW = 0;
   localparam int K_RR = 1;
   localparam int K_BW = 2;
   localparam int K_BR = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sck = 1'b0;
   logic       mosi = 1'b0;
   logic       miso;
   logic       miso_oe;
   logic       reg_wr, reg_rd, buf_wr, buf_rd;
   logic [4:0] addr;
   logic [7:0] wdata;
   logic [7:0] reg_rdata;
   logic [7:0] buf_rdata;

   always #2.5 clk = ~clk;

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   int    buf_pops [8] = '{default: 0};
   int    exp_pops [8] = '{default: 0};
   int    exp_q [$];
   string tag_q [$];
   string cur_tag = "R11";

   function automatic logic [7:0] reg_val(input int a);
      return 8'((a * 37 + 11) & 255);
   endfunction

   // Environment: register file and buffer heads seen by the block
   assign reg_rdata = reg_val(int'(addr));
   assign buf_rdata = {addr[2:0], 5'(buf_pops[addr[2:0]])};

   always @(posedge clk) begin
      if (buf_rd) buf_pops[addr[2:0]] <= buf_pops[addr[2:0]] + 1;
   end

   spi_cmd_slave u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_cs_n    (cs_n),
      .spi_sck     (sck),
      .spi_mosi    (mosi),
      .spi_miso    (miso),
      .spi_miso_oe (miso_oe),
      .reg_wr_o    (reg_wr),
      .reg_rd_o    (reg_rd),
      .buf_wr_o    (buf_wr),
      .buf_rd_o    (buf_rd),
      .addr_o      (addr),
      .wdata_o     (wdata),
      .reg_rdata_i (reg_rdata),
      .buf_rdata_i (buf_rdata)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic int ev(input int kind, input int a, input int d);
      return (kind << 16) | (a << 8) | d;
   endfunction

   task automatic expect_ev(input int kind, input int a, input int d, input string tag);
      exp_q.push_back(ev(kind, a, d));
      tag_q.push_back(tag);
   endtask

   // Compare every strobe against the model's predicted sequence, each clock
   always @(negedge clk) begin
      if (rst_n) begin
         int n;
         int got;
         n = int'(reg_wr) + int'(reg_rd) + int'(buf_wr) + int'(buf_rd);
         if (n > 1) check(0, cur_tag, n, 1);
         else if (n == 1) begin
            if (reg_wr)      got = ev(K_RW, int'(addr), int'(wdata));
            else if (reg_rd) got = ev(K_RR, int'(addr), 0);
            else if (buf_wr) got = ev(K_BW, int'(addr), int'(wdata));
            else             got = ev(K_BR, int'(addr), 0);
            if (exp_q.size() == 0) check(0, cur_tag, got, -1);
            else begin
               int    e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(got == e, t, got, e);
            end
         end
      end
   end

   task automatic spi_bits(input logic [7:0] v, input int n, output logic [7:0] r);
      r = '0;
      for (int i = 0; i < n; i++) begin
         mosi = v[7-i];
         repeat (4) @(negedge clk);
         r = {r[6:0], miso};
         sck = 1'b1;
         repeat (4) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic xfer(input logic [7:0] v, output logic [7:0] r);
      spi_bits(v, 8, r);
   endtask

   task automatic spi_begin(input string tag);
      cur_tag = tag;
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      check(miso_oe == 1'b1, "R10", int'(miso_oe), 1);
   endtask

   task automatic spi_end();
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
      check(miso_oe == 1'b0, "R10", int'(miso_oe), 0);
      check(exp_q.size() == 0, cur_tag, exp_q.size(), 0);
      exp_q.delete();
      tag_q.delete();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      int         p;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: idle state after reset
      check(miso_oe == 1'b0, "R11", int'(miso_oe), 0);
      check(miso == 1'b0, "R11", int'(miso), 0);
      check({reg_wr, reg_rd, buf_wr, buf_rd} == 4'b0, "R11",
            int'({reg_wr, reg_rd, buf_wr, buf_rd}), 0);

      // R1/R2: write with don't-care bits 6 and 5 set, asymmetric data
      expect_ev(K_RW, 3, 8'hC1, "R1");
      spi_begin("R1");
      xfer(8'hE3, r);
      check(r == 8'h00, "R2", r, 0);
      xfer(8'hC1, r);
      spi_end();

      // R3: trailing bytes after a register write are ignored
      expect_ev(K_RW, 5, 8'h3C, "R3");
      spi_begin("R3");
      xfer(8'h85, r);
      xfer(8'h3C, r);
      xfer(8'hFF, r);
      xfer(8'hA5, r);
      spi_end();

      // R4: abort after 15 bits, and after 11 bits
      spi_begin("R4");
      xfer(8'h86, r);
      spi_bits(8'hFF, 7, r);
      spi_end();
      spi_begin("R4");
      xfer(8'h82, r);
      spi_bits(8'h5A, 3, r);
      spi_end();

      // R5: register read, mode bit ignored for registers
      expect_ev(K_RR, 4, 0, "R5");
      spi_begin("R5");
      xfer(8'h64, r);
      xfer(8'h00, r);
      check(r == reg_val(4), "R5", r, reg_val(4));
      xfer(8'h00, r);
      check(r == 8'h00, "R5", r, 0);
      spi_end();

      // R2: bit order on SDO (0xC7 would read 0xE3 if reversed)
      expect_ev(K_RR, 12, 0, "R2");
      spi_begin("R2");
      xfer(8'h0C, r);
      xfer(8'h00, r);
      check(r == reg_val(12), "R2", r, reg_val(12));
      spi_end();

      // R6: buffer write burst with a partial trailing byte
      expect_ev(K_BW, 18, 8'h11, "R6");
      expect_ev(K_BW, 18, 8'h82, "R6");
      expect_ev(K_BW, 18, 8'h33, "R6");
      spi_begin("R6");
      xfer(8'h92, r);
      xfer(8'h11, r);
      xfer(8'h82, r);
      xfer(8'h33, r);
      spi_bits(8'hFF, 3, r);
      spi_end();

      // R7: continuous buffer read, three full bytes
      p = exp_pops[3];
      for (int k = 0; k < 4; k++) expect_ev(K_BR, 19, 0, "R7");
      spi_begin("R7");
      xfer(8'h13, r);
      for (int k = 0; k < 3; k++) begin
         xfer(8'h00, r);
         check(r == {3'd3, 5'(p + k)}, "R7", r, {3'd3, 5'(p + k)});
      end
      spi_end();
      exp_pops[3] = p + 4;

      // R7: continuous read cut short mid-byte
      p = exp_pops[0];
      expect_ev(K_BR, 16, 0, "R7");
      expect_ev(K_BR, 16, 0, "R7");
      spi_begin("R7");
      xfer(8'h10, r);
      xfer(8'h00, r);
      check(r == {3'd0, 5'(p)}, "R7", r, {3'd0, 5'(p)});
      spi_bits(8'h00, 4, r);
      spi_end();
      exp_pops[0] = p + 2;

      // R8: single-mode buffer read
      p = exp_pops[5];
      expect_ev(K_BR, 21, 0, "R8");
      spi_begin("R8");
      xfer(8'h55, r);
      xfer(8'h00, r);
      check(r == {3'd5, 5'(p)}, "R8", r, {3'd5, 5'(p)});
      xfer(8'h00, r);
      check(r == 8'h00, "R8", r, 0);
      spi_end();
      exp_pops[5] = p + 1;

      // R9: unused addresses
      spi_begin("R9");
      xfer(8'h09, r);
      xfer(8'h00, r);
      check(r == 8'h00, "R9", r, 0);
      spi_end();
      spi_begin("R9");
      xfer(8'h1A, r);
      xfer(8'h00, r);
      check(r == 8'h00, "R9", r, 0);
      xfer(8'h00, r);
      check(r == 8'h00, "R9", r, 0);
      spi_end();
      spi_begin("R9");
      xfer(8'h0D, r);
      xfer(8'h00, r);
      check(r == 8'h00, "R9", r, 0);
      spi_end();
      spi_begin("R9");
      xfer(8'h8E, r);
      xfer(8'h77, r);
      spi_end();
      spi_begin("R9");
      xfer(8'h9F, r);
      xfer(8'h01, r);
      xfer(8'h02, r);
      spi_end();

      // R1: a write to a buffer address with bit 6 set still writes
      expect_ev(K_BW, 20, 8'h6D, "R1");
      spi_begin("R1");
      xfer(8'hD4, r);
      xfer(8'h6D, r);
      spi_end();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule